// File: doc/BRIEF.md
# Reseeded Accumulator Test Pattern Generator

This block turns a plain adder accumulator into a source of deterministic test patterns for a circuit under test. A small read-only seed table lists a sequence of runs. Each entry gives a starting register value, an addend and a run length. When a run begins, the register takes the starting value. On every following cycle the addend is added to it, modulo 2^W, and each register value is presented as one test pattern.

When a run ends, the next table entry is loaded with no gap. After the final entry has run, the block reports completion. A cap on the total number of patterns per session ends generation early if the table would exceed it. A single start pulse launches a whole session. Computing the seeds and compacting the responses happen elsewhere.

Top module: `seedacc_patgen`

## Requirements
- R1: Within a run, every pattern after the first equals the previous pattern plus that run's addend, truncated to W bits. With the default table, run 0 gives FE, FF, 00, 01.
- R2: A start pulse is accepted when the block is idle or done. The first pattern appears at the rising edge that follows the edge where start was sampled. The output at that following edge is the starting value of table entry 0.
- R3: A table entry whose length field holds L produces exactly L+1 patterns. While it runs, `seed_idx_o` shows that entry's index.
- R4: The first pattern of entry i+1 follows the last pattern of entry i in the very next cycle. `pattern_valid_o` stays high across every run boundary, and `seed_idx_o` increases by exactly one there.
- R5: Table word i is packed as {start value[W], addend[W], length[LEN_W]}, with the start value in the most significant bits. The start value is (R0_BASE + i*R0_STRIDE) mod 2^W, the addend is 2i+1 and the length field is NUM_SEEDS-1-i. With the defaults this gives the sequence FE FF 00 01 33 36 39 68 6D 9D.
- R6: `pattern_valid_o` is high for exactly one cycle per pattern. One cycle after the last pattern, it is low and `done_o` is high. `done_o` then stays high until a start is accepted, and it is never high together with `pattern_valid_o`.
- R7: A start pulse that arrives while a session is running is ignored. The session's pattern sequence and length are unchanged.
- R8: A session never emits more than BUDGET patterns. When the count reaches BUDGET, generation stops and `done_o` rises in the next cycle, even if table entries remain.
- R9: Reset clears the pattern register to 0, the seed index to 0 and the run counter, and drives `pattern_valid_o` and `done_o` low.
- R10: A start accepted after completion clears `done_o` and replays the whole sequence from table entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a session when idle or done |
| pattern_o | output | W | Current test pattern (accumulator register) |
| pattern_valid_o | output | 1 | High for each cycle that carries a new pattern |
| seed_idx_o | output | IDX_W | Index of the table entry being run |
| done_o | output | 1 | Session finished; held until the next accepted start |

## Verification
The assertions assume that `start_i` is synchronous to the clock and is the only input that changes outside reset. They also assume the table holds at least two entries, so that the index width is non-zero. The bench changes `start_i` only on falling clock edges and releases reset before the first start. It pulses start in three situations: during a run, on a run's last cycle, and after completion. It runs a second instance with a small BUDGET so that the truncation path is exercised under the same stimulus.

// File: rtl/seedacc_pkg.sv
package seedacc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seedacc_rom.sv
module seedacc_rom #(
  parameter int W         = 8,
  parameter int LEN_W     = 4,
  parameter int NUM_SEEDS = 4,
  parameter int R0_BASE   = 254,
  parameter int R0_STRIDE = 53,
  localparam int IDX_W    = $clog2(NUM_SEEDS),
  localparam int WORD_W   = 2 * W + LEN_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  addr_i,
  output logic [W-1:0]      r0_o,
  output logic [W-1:0]      c_o,
  output logic [LEN_W-1:0]  len_o
);
  // Table contents are computed, so no literal list is needed.
  function automatic logic [WORD_W-1:0] seed_word(input logic [IDX_W-1:0] i);
    int idx;
    logic [W-1:0]     r0;
    logic [W-1:0]     c;
    logic [LEN_W-1:0] len;
    idx = int'(i);
    r0  = W'(R0_BASE + idx * R0_STRIDE);
    c   = W'(2 * idx + 1);
    len = LEN_W'(NUM_SEEDS - 1 - idx);
    return {r0, c, len};
  endfunction

  logic [WORD_W-1:0] word_q;

  // Synchronous read: maps onto a block memory in ROM mode.
  always_ff @(posedge clk_i) begin
    word_q <= seed_word(addr_i);
  end

  assign r0_o  = word_q[WORD_W-1 -: W];
  assign c_o   = word_q[LEN_W +: W];
  assign len_o = word_q[LEN_W-1:0];
endmodule

// File: rtl/seedacc_accum.sv
module seedacc_accum #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] r0_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] pat_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] add_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q <= '0;
      add_q <= '0;
    end else if (load_i) begin
      acc_q <= r0_i;
      add_q <= c_i;
    end else if (step_i) begin
      acc_q <= acc_q + add_q;
    end
  end

  assign pat_o = acc_q;
  assign c_o   = add_q;
endmodule

// File: rtl/seedacc_seq.sv
module seedacc_seq
  import seedacc_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int NUM_SEEDS = 4,
  parameter int BUDGET    = 64,
  localparam int IDX_W    = $clog2(NUM_SEEDS),
  localparam int TOT_W    = $clog2(BUDGET + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [IDX_W-1:0]  addr_o,
  output logic              load_o,
  output logic              step_o,
  output logic              valid_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  seed_idx_o,
  output logic [TOT_W-1:0]  total_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SEEDS - 1);
  localparam logic [TOT_W-1:0] CAP      = TOT_W'(BUDGET);

  seq_state_t       st_q, st_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [IDX_W-1:0] fetch_q, fetch_n;
  logic [TOT_W-1:0] tot_q, tot_n;
  logic             valid_q, valid_n;
  logic             done_q, done_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    fetch_n = fetch_q;
    tot_n   = tot_q;
    valid_n = 1'b0;
    done_n  = done_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_n    = ST_LOAD;
          fetch_n = '0;
          done_n  = 1'b0;
        end
      end
      ST_LOAD: begin
        load_o  = 1'b1;
        cnt_n   = len_i;
        idx_n   = '0;
        fetch_n = (fetch_q == LAST_IDX) ? fetch_q : fetch_q + 1'b1;
        tot_n   = TOT_W'(1);
        valid_n = 1'b1;
        st_n    = ST_RUN;
      end
      ST_RUN: begin
        if (tot_q == CAP || (cnt_q == '0 && idx_q == LAST_IDX)) begin
          st_n   = ST_DONE;
          done_n = 1'b1;
        end else if (cnt_q != '0) begin
          step_o  = 1'b1;
          cnt_n   = cnt_q - 1'b1;
          tot_n   = tot_q + 1'b1;
          valid_n = 1'b1;
        end else begin
          load_o  = 1'b1;
          cnt_n   = len_i;
          idx_n   = idx_q + 1'b1;
          fetch_n = (fetch_q == LAST_IDX) ? fetch_q : fetch_q + 1'b1;
          tot_n   = tot_q + 1'b1;
          valid_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      fetch_q <= '0;
      tot_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      fetch_q <= fetch_n;
      tot_q   <= tot_n;
      valid_q <= valid_n;
      done_q  <= done_n;
    end
  end

  // Look-ahead address: the table word is ready one cycle before it is loaded.
  assign addr_o     = fetch_n;
  assign valid_o    = valid_q;
  assign done_o     = done_q;
  assign seed_idx_o = idx_q;
  assign total_o    = tot_q;
endmodule

// File: rtl/seedacc_patgen.sv
module seedacc_patgen #(
  parameter int W         = 8,
  parameter int LEN_W     = 4,
  parameter int NUM_SEEDS = 4,
  parameter int BUDGET    = 64,
  parameter int R0_BASE   = 254,
  parameter int R0_STRIDE = 53,
  localparam int IDX_W    = $clog2(NUM_SEEDS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  output logic [W-1:0]     pattern_o,
  output logic             pattern_valid_o,
  output logic [IDX_W-1:0] seed_idx_o,
  output logic             done_o
);
  localparam int TOT_W = $clog2(BUDGET + 1);

  logic [IDX_W-1:0] rom_addr;
  logic [W-1:0]     rom_r0;
  logic [W-1:0]     rom_c;
  logic [LEN_W-1:0] rom_len;
  logic             acc_load;
  logic             acc_step;
  logic [W-1:0]     c_cur;
  logic [TOT_W-1:0] total;

  seedacc_rom #(
    .W(W), .LEN_W(LEN_W), .NUM_SEEDS(NUM_SEEDS),
    .R0_BASE(R0_BASE), .R0_STRIDE(R0_STRIDE)
  ) u_rom (
    .clk_i (clk_i),
    .addr_i(rom_addr),
    .r0_o  (rom_r0),
    .c_o   (rom_c),
    .len_o (rom_len)
  );

  seedacc_seq #(
    .LEN_W(LEN_W), .NUM_SEEDS(NUM_SEEDS), .BUDGET(BUDGET)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .len_i     (rom_len),
    .addr_o    (rom_addr),
    .load_o    (acc_load),
    .step_o    (acc_step),
    .valid_o   (pattern_valid_o),
    .done_o    (done_o),
    .seed_idx_o(seed_idx_o),
    .total_o   (total)
  );

  seedacc_accum #(.W(W)) u_acc (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(acc_load),
    .step_i(acc_step),
    .r0_i  (rom_r0),
    .c_i   (rom_c),
    .pat_o (pattern_o),
    .c_o   (c_cur)
  );
endmodule

// File: rtl/seedacc_patgen_chk.sv
module seedacc_patgen_chk #(
  parameter int W         = 8,
  parameter int NUM_SEEDS = 4,
  parameter int BUDGET    = 64,
  localparam int IDX_W    = $clog2(NUM_SEEDS),
  localparam int TOT_W    = $clog2(BUDGET + 1)
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start_i,
  input logic [W-1:0]     pattern_o,
  input logic             pattern_valid_o,
  input logic [IDX_W-1:0] seed_idx_o,
  input logic             done_o,
  input logic [W-1:0]     c_cur,
  input logic [TOT_W-1:0] total
);
  assert_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (pattern_valid_o && $past(pattern_valid_o) && seed_idx_o == $past(seed_idx_o))
      |-> pattern_o == W'($past(pattern_o) + $past(c_cur)));

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(seed_idx_o) <= NUM_SEEDS - 1);

  assert_idx_advance_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (pattern_valid_o && $past(pattern_valid_o) && seed_idx_o != $past(seed_idx_o))
      |-> seed_idx_o == IDX_W'($past(seed_idx_o) + 1'b1));

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(pattern_valid_o && done_o));

  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !start_i) |=> done_o);

  assert_done_clear_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(done_o) |-> $past(start_i));

  assert_budget_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(total) <= BUDGET);

  assert_reset_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!pattern_valid_o && !done_o));
endmodule

bind seedacc_patgen seedacc_patgen_chk #(
  .W(W), .NUM_SEEDS(NUM_SEEDS), .BUDGET(BUDGET)
) u_chk (
  .clk_i          (clk_i),
  .rst_i          (rst_i),
  .start_i        (start_i),
  .pattern_o      (pattern_o),
  .pattern_valid_o(pattern_valid_o),
  .seed_idx_o     (seed_idx_o),
  .done_o         (done_o),
  .c_cur          (c_cur),
  .total          (total)
);

// File: tb/sim_seedacc_patgen.sv
`timescale 1ns/1ps
module sim_seedacc_patgen;
  localparam int W      = 8;
  localparam int NS     = 4;
  localparam int IW     = 2;
  localparam int BASE   = 254;
  localparam int STRIDE = 53;
  localparam int NPAT   = 10;
  localparam int SMALL  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0]  pat0, pat1;
  logic          val0, val1, done0, done1;
  logic [IW-1:0] idx0, idx1;

  int checks = 0;
  int errors = 0;
  int exp_pat [NPAT];
  int exp_idx [NPAT];

  always #4 clk = ~clk;

  seedacc_patgen #(.W(W), .LEN_W(4), .NUM_SEEDS(NS), .BUDGET(64),
    .R0_BASE(BASE), .R0_STRIDE(STRIDE)) u0 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .pattern_o(pat0),
    .pattern_valid_o(val0), .seed_idx_o(idx0), .done_o(done0));

  seedacc_patgen #(.W(W), .LEN_W(4), .NUM_SEEDS(NS), .BUDGET(SMALL),
    .R0_BASE(BASE), .R0_STRIDE(STRIDE)) u1 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .pattern_o(pat1),
    .pattern_valid_o(val1), .seed_idx_o(idx1), .done_o(done1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build_expect();
    int k = 0;
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j <= NS - 1 - s; j++) begin
        exp_pat[k] = (BASE + s * STRIDE + j * (2 * s + 1)) % 256;
        exp_idx[k] = s;
        k++;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pat0 == 0, "R9 pattern", int'(pat0), 0);
    chk(idx0 == 0, "R9 seed index", int'(idx0), 0);
    chk(!val0 && !done0, "R9 valid/done", {val0, done0}, 0);
  endtask

  // One session; an extra start is pulsed at pattern busy_at (-1: none).
  task automatic t_session(input int busy_at, input string tag);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!val0, {tag, " R2 no pattern yet"}, int'(val0), 0);
    chk(!done0, {tag, " R10 done cleared"}, int'(done0), 0);
    for (int k = 0; k < NPAT; k++) begin
      @(negedge clk);
      chk(val0, {tag, " R4 valid continuous"}, int'(val0), 1);
      chk(int'(pat0) == exp_pat[k], {tag, " R1/R5 pattern"}, int'(pat0), exp_pat[k]);
      chk(int'(idx0) == exp_idx[k], {tag, " R3 seed index"}, int'(idx0), exp_idx[k]);
      if (k < SMALL)
        chk(val1 && int'(pat1) == exp_pat[k], {tag, " R8 capped pattern"}, int'(pat1), exp_pat[k]);
      else if (k == SMALL)
        chk(!val1 && done1, {tag, " R8 cap done"}, {val1, done1}, 1);
      start = (k == busy_at);
    end
    @(negedge clk) start = 1'b0;
    chk(!val0 && done0, {tag, " R6 done after last"}, {val0, done0}, 1);
    chk(int'(pat0) == exp_pat[NPAT-1], {tag, " R7 no restart"}, int'(pat0), exp_pat[NPAT-1]);
    repeat (5) begin
      @(negedge clk);
      chk(done0 && !val0, {tag, " R6 done held"}, {val0, done0}, 1);
    end
  endtask

  initial begin
    build_expect();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_session(-1, "plain");
    t_session(3, "busy_mid");
    t_session(NPAT - 1, "busy_last");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule